// File: doc/BRIEF.md
# Ping-pong posted-write burst buffer

This block sits between a bus target and a memory controller and absorbs posted write bursts. Two equal word banks take turns. Bus words fill one bank. When that bank reaches the depth in force for the current transaction, it is closed and handed to the memory side as exactly one burst. The other bank then takes the following bus words. If the bus burst ends early, the partly filled bank is closed at once and drained as a shorter burst.

The depth is 8 or 16 words. A one-bit setting is held per address window, and the window of the transaction's first word selects it. Each memory burst starts with a request that carries the byte address and the word count minus one. 64-bit data beats follow, each packing two 32-bit words, so no burst exceeds eight beats.

The bus side is stalled when both banks hold data. A new bus burst waits until everything from the previous one has left for memory.

Top module: `pp_post_buf`

## Requirements
- R1: When the first word of a bus burst is accepted, the depth is latched for the whole burst from `burst_long_i[bus_win_i]`. A value of 0 gives 8 words and 1 gives 16 words. Later changes to the setting within the burst have no effect.
- R2: Words go into one bank until it holds the latched depth. The next word goes into the other bank, and memory receives all words in bus order.
- R3: Each closed bank produces exactly one memory request, never split. `mem_req_len_o` is that bank's word count minus one.
- R4: Accepting a word with `bus_last_i`=1 closes the current bank even when it is partly filled. For example, 10 words at depth 8 give a burst of 8 words followed by a burst of 2 words.
- R5: No memory request is raised while the first bank of a burst is still filling and no word with `bus_last_i` has arrived.
- R6: The request address is the address of the bus burst's first word plus 4 times the number of words of that burst placed in earlier banks.
- R7: Each beat carries word 2k in bits [31:0] and word 2k+1 in bits [63:32]. `mem_beat_mask_o` bit 0 marks the low word valid (always 1) and bit 1 marks the high word valid. `mem_beat_last_o` flags the final beat of a burst. A burst has at most 8 beats.
- R8: While the bank being filled is closed and waiting behind the bank being drained, `bus_ready_o` is 0.
- R9: After a word with `bus_last_i`, `bus_ready_o` stays 0 until both banks have fully drained.
- R10: A raised request keeps its address and length until `mem_req_ready_i`. A raised beat keeps its data, mask and last flag until `mem_beat_ready_i`.
- R11: After reset, `bus_ready_o` is 1 and `mem_req_valid_o` and `mem_beat_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_long_i | input | NUM_WIN | Per-window depth setting (0: 8 words, 1: 16 words) |
| bus_valid_i | input | 1 | Bus write word valid |
| bus_ready_o | output | 1 | Block accepts a bus word |
| bus_data_i | input | WORD_W | Bus write word |
| bus_last_i | input | 1 | Word is the last of the bus burst |
| bus_addr_i | input | ADDR_W | Byte address of the burst, used at the first word |
| bus_win_i | input | clog2(NUM_WIN) | Address window hit, used at the first word |
| mem_req_valid_o | output | 1 | Memory burst request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Burst start byte address |
| mem_req_len_o | output | clog2(LONG_DEPTH) | Words in burst minus one |
| mem_beat_valid_o | output | 1 | Data beat valid |
| mem_beat_ready_i | input | 1 | Memory accepts the beat |
| mem_beat_data_o | output | 2*WORD_W | Two packed words |
| mem_beat_mask_o | output | 2 | Word-valid mask, bit 0 low word |
| mem_beat_last_o | output | 1 | Final beat of the burst |

## Verification
A wrong bank selector or a count that was not cleared shows up on the first memory request after the fault. It appears as a wrong length, a wrong address, or words out of order in the next beat. A close flag stuck high freezes `bus_ready_o` low within a cycle. A lost close means the request never appears and remaining words never drain. A latch of the depth setting after the first word shows up as a wrongly split burst under per-cycle random changes of the setting. Because every beat is compared with the expected word stream, misordering is caught on the first swapped word.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  typedef enum logic [1:0] {
    DR_IDLE,
    DR_REQ,
    DR_DATA
  } drain_st_e;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PAIR_W = $clog2(DEPTH / 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic [PAIR_W-1:0] pair_idx_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [WORD_W-1:0] hi_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wr_en_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[cnt_q[IDX_W-1:0]] <= wr_data_i;
  end

  assign cnt_o = cnt_q;
  assign lo_o  = mem_q[{pair_idx_i, 1'b0}];
  assign hi_o  = mem_q[{pair_idx_i, 1'b1}];

  // R2
  bank_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> cnt_q < CNT_W'(DEPTH));
  // R8
  bank_no_write_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && clr_i));
endmodule

// File: rtl/pp_drain.sv
module pp_drain
  import pp_buf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LEN_W  = $clog2(DEPTH),
  localparam int PAIR_W = $clog2(DEPTH / 2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pend_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [WORD_W-1:0]   lo_i,
  input  logic [WORD_W-1:0]   hi_i,
  input  logic                req_ready_i,
  input  logic                beat_ready_i,
  output logic [PAIR_W-1:0]   pair_idx_o,
  output logic                done_o,
  output logic                req_valid_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [LEN_W-1:0]    req_len_o,
  output logic                beat_valid_o,
  output logic [2*WORD_W-1:0] beat_data_o,
  output logic [1:0]          beat_mask_o,
  output logic                beat_last_o
);
  drain_st_e         st_q;
  logic [PAIR_W-1:0] pair_q;
  logic [CNT_W-1:0]  words_done;
  logic              hi_ok, last_beat;

  assign words_done = CNT_W'({pair_q, 1'b0});
  assign hi_ok      = (words_done + CNT_W'(1)) < cnt_i;
  assign last_beat  = (words_done + CNT_W'(2)) >= cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DR_IDLE;
      pair_q <= '0;
    end else begin
      unique case (st_q)
        DR_IDLE: if (pend_i) st_q <= DR_REQ;
        DR_REQ: if (req_ready_i) begin
          st_q   <= DR_DATA;
          pair_q <= '0;
        end
        DR_DATA: if (beat_ready_i) begin
          if (last_beat) st_q <= DR_IDLE;
          else           pair_q <= pair_q + PAIR_W'(1);
        end
        default: st_q <= DR_IDLE;
      endcase
    end
  end

  assign pair_idx_o   = pair_q;
  assign done_o       = (st_q == DR_DATA) && beat_ready_i && last_beat;
  assign req_valid_o  = (st_q == DR_REQ);
  assign req_addr_o   = addr_i;
  assign req_len_o    = LEN_W'(cnt_i - CNT_W'(1));
  assign beat_valid_o = (st_q == DR_DATA);
  assign beat_data_o  = {hi_i, lo_i};
  assign beat_mask_o  = {hi_ok, 1'b1};
  assign beat_last_o  = last_beat;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));
  // R10
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_data_o)
      && $stable(beat_mask_o) && $stable(beat_last_o));
  // R7
  beat_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> words_done < cnt_i);
endmodule

// File: rtl/pp_post_buf.sv
module pp_post_buf #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int NUM_WIN     = 4,
  parameter int SHORT_DEPTH = 8,
  parameter int LONG_DEPTH  = 16,
  localparam int WIN_W  = $clog2(NUM_WIN),
  localparam int CNT_W  = $clog2(LONG_DEPTH + 1),
  localparam int LEN_W  = $clog2(LONG_DEPTH),
  localparam int PAIR_W = $clog2(LONG_DEPTH / 2)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WIN-1:0]  burst_long_i,
  input  logic                bus_valid_i,
  output logic                bus_ready_o,
  input  logic [WORD_W-1:0]   bus_data_i,
  input  logic                bus_last_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [WIN_W-1:0]    bus_win_i,
  output logic                mem_req_valid_o,
  input  logic                mem_req_ready_i,
  output logic [ADDR_W-1:0]   mem_req_addr_o,
  output logic [LEN_W-1:0]    mem_req_len_o,
  output logic                mem_beat_valid_o,
  input  logic                mem_beat_ready_i,
  output logic [2*WORD_W-1:0] mem_beat_data_o,
  output logic [1:0]          mem_beat_mask_o,
  output logic                mem_beat_last_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic              in_burst_q, long_q, fill_sel_q, drain_sel_q;
  logic [1:0]        closed_q;
  logic [ADDR_W-1:0] nxt_addr_q;
  logic [ADDR_W-1:0] bank_addr_q [2];
  logic [CNT_W-1:0]  bank_cnt [2];
  logic [WORD_W-1:0] bank_lo [2];
  logic [WORD_W-1:0] bank_hi [2];
  logic [1:0]        bank_wr, bank_clr;
  logic [PAIR_W-1:0] pair_idx;
  logic              acc, close, done, cur_long;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  lim, fill_cnt;

  // first word of a burst takes window setting and address from the bus
  assign cur_long = in_burst_q ? long_q : burst_long_i[bus_win_i];
  assign cur_addr = in_burst_q ? nxt_addr_q : bus_addr_i;
  assign lim      = cur_long ? CNT_W'(LONG_DEPTH) : CNT_W'(SHORT_DEPTH);
  assign fill_cnt = bank_cnt[fill_sel_q];

  assign bus_ready_o = in_burst_q ? !closed_q[fill_sel_q] : (closed_q == 2'b00);
  assign acc         = bus_valid_i && bus_ready_o;
  assign close       = acc && (bus_last_i || (fill_cnt + CNT_W'(1) == lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_burst_q  <= 1'b0;
      long_q      <= 1'b0;
      fill_sel_q  <= 1'b0;
      drain_sel_q <= 1'b0;
      closed_q    <= '0;
      nxt_addr_q  <= '0;
      for (int b = 0; b < 2; b++) bank_addr_q[b] <= '0;
    end else begin
      if (acc) begin
        in_burst_q <= !bus_last_i;
        long_q     <= cur_long;
        nxt_addr_q <= cur_addr + STEP;
        if (fill_cnt == '0) bank_addr_q[fill_sel_q] <= cur_addr;
      end
      if (close) fill_sel_q <= !fill_sel_q;
      if (done)  drain_sel_q <= !drain_sel_q;
      for (int b = 0; b < 2; b++) begin
        if (close && (fill_sel_q == 1'(b)))      closed_q[b] <= 1'b1;
        else if (done && (drain_sel_q == 1'(b))) closed_q[b] <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_wr[b]  = acc && (fill_sel_q == 1'(b));
    assign bank_clr[b] = done && (drain_sel_q == 1'(b));
    pp_bank #(
      .WORD_W(WORD_W),
      .DEPTH (LONG_DEPTH)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_wr[b]),
      .wr_data_i (bus_data_i),
      .clr_i     (bank_clr[b]),
      .pair_idx_i(pair_idx),
      .cnt_o     (bank_cnt[b]),
      .lo_o      (bank_lo[b]),
      .hi_o      (bank_hi[b])
    );
  end

  pp_drain #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .DEPTH (LONG_DEPTH)
  ) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (closed_q[drain_sel_q]),
    .addr_i      (bank_addr_q[drain_sel_q]),
    .cnt_i       (bank_cnt[drain_sel_q]),
    .lo_i        (bank_lo[drain_sel_q]),
    .hi_i        (bank_hi[drain_sel_q]),
    .req_ready_i (mem_req_ready_i),
    .beat_ready_i(mem_beat_ready_i),
    .pair_idx_o  (pair_idx),
    .done_o      (done),
    .req_valid_o (mem_req_valid_o),
    .req_addr_o  (mem_req_addr_o),
    .req_len_o   (mem_req_len_o),
    .beat_valid_o(mem_beat_valid_o),
    .beat_data_o (mem_beat_data_o),
    .beat_mask_o (mem_beat_mask_o),
    .beat_last_o (mem_beat_last_o)
  );

  // R9
  new_burst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !in_burst_q |-> bank_cnt[0] == '0 && bank_cnt[1] == '0);
  // R8
  fill_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> !closed_q[fill_sel_q]);
  // R5
  req_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> closed_q[drain_sel_q]);
  // R1
  depth_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst_q |-> fill_cnt <= (long_q ? CNT_W'(LONG_DEPTH) : CNT_W'(SHORT_DEPTH)));
endmodule

// File: tb/pp_post_buf_tb_top.sv
module pp_post_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  burst_long;
  logic        bus_valid, bus_ready, bus_last;
  logic [31:0] bus_data, bus_addr;
  logic [1:0]  bus_win;
  logic        req_valid, req_ready, beat_valid, beat_ready, beat_last;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic [63:0] beat_data;
  logic [1:0]  beat_mask;

  always #4 clk = ~clk;

  pp_post_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .burst_long_i(burst_long),
    .bus_valid_i(bus_valid), .bus_ready_o(bus_ready), .bus_data_i(bus_data),
    .bus_last_i(bus_last), .bus_addr_i(bus_addr), .bus_win_i(bus_win),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_req_addr_o(req_addr), .mem_req_len_o(req_len),
    .mem_beat_valid_o(beat_valid), .mem_beat_ready_i(beat_ready),
    .mem_beat_data_o(beat_data), .mem_beat_mask_o(beat_mask),
    .mem_beat_last_o(beat_last)
  );

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;
  logic [31:0] q_addr[$];
  logic [3:0]  q_len[$];
  logic [31:0] q_word[$];
  int req_seen = 0;
  int mem_mode = 2;
  bit rand_cfg = 1'b0;

  // monitor state
  int left = 0, beats = 0;
  bit prev_wait = 1'b0;
  logic [31:0] prev_addr, ea, ew;
  logic [3:0]  prev_len, el;
  bit exp_hi;

  // model state
  bit in_b = 1'b0;
  int depth_b = 8, chunk = 0, widx = 0;
  logic [31:0] base_b, chunk_addr;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int depth_of(logic [3:0] cfg, logic [1:0] w);
    return cfg[w] ? 16 : 8;
  endfunction

  task automatic model_accept(logic [31:0] d, bit last);
    if (!in_b) begin
      in_b    = 1'b1;
      depth_b = depth_of(burst_long, bus_win);
      base_b  = bus_addr;
      widx    = 0;
      chunk   = 0;
    end
    if (chunk == 0) chunk_addr = base_b + 32'(4 * widx);
    q_word.push_back(d);
    widx++;
    chunk++;
    if (chunk == depth_b || last) begin
      q_addr.push_back(chunk_addr);
      q_len.push_back(4'(chunk - 1));
      chunk = 0;
    end
    if (last) in_b = 1'b0;
  endtask

  // memory side: drive ready, then score what fires at the next edge
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready  = 1'b0;
      beat_ready = 1'b0;
    end else begin
      case (mem_mode)
        0: begin
          req_ready  = ($urandom % 3) != 0;
          beat_ready = ($urandom % 4) != 0;
        end
        1: begin
          req_ready  = 1'b0;
          beat_ready = 1'b0;
        end
        default: begin
          req_ready  = 1'b1;
          beat_ready = 1'b1;
        end
      endcase
      if (prev_wait)
        chk(req_valid && req_addr == prev_addr && req_len == prev_len,
            "R10 request hold", 64'(req_addr), 64'(prev_addr));
      prev_wait = req_valid && !req_ready;
      prev_addr = req_addr;
      prev_len  = req_len;
      if (req_valid && req_ready) begin
        req_seen++;
        if (q_addr.size() == 0) begin
          chk(1'b0, "R5 unexpected request", 64'(req_addr), 64'(0));
        end else begin
          ea = q_addr.pop_front();
          el = q_len.pop_front();
          chk(req_addr == ea, "R6 request address", 64'(req_addr), 64'(ea));
          chk(req_len == el, "R1/R3 request length", 64'(req_len), 64'(el));
          left  = int'(el) + 1;
          beats = 0;
        end
      end
      if (beat_valid && beat_ready) begin
        beats++;
        chk(beats <= 8, "R7 beats per burst", 64'(beats), 64'(8));
        exp_hi = left >= 2;
        chk(beat_mask == {exp_hi, 1'b1}, "R7 mask", 64'(beat_mask), 64'({exp_hi, 1'b1}));
        ew = (q_word.size() != 0) ? q_word.pop_front() : 32'hDEAD_BEEF;
        chk(beat_data[31:0] == ew, "R2/R4 low word", 64'(beat_data[31:0]), 64'(ew));
        if (exp_hi) begin
          ew = (q_word.size() != 0) ? q_word.pop_front() : 32'hDEAD_BEEF;
          chk(beat_data[63:32] == ew, "R2/R7 high word", 64'(beat_data[63:32]), 64'(ew));
          left -= 2;
        end else begin
          left -= 1;
        end
        chk(beat_last == (left <= 0), "R7 last flag", 64'(beat_last), 64'(left <= 0));
      end
    end
  end

  task automatic send_word(bit last);
    logic [31:0] d;
    d = $urandom;
    forever begin
      @(negedge clk);
      if (rand_cfg) burst_long = 4'($urandom);
      bus_valid = 1'b1;
      bus_data  = d;
      bus_last  = last;
      if (bus_ready) break;
    end
    model_accept(d, last);
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic send_burst(int n, logic [31:0] a, logic [1:0] w);
    bus_addr = a;
    bus_win  = w;
    for (int i = 0; i < n; i++) send_word(i == n - 1);
  endtask

  task automatic drain_wait();
    while (q_addr.size() != 0 || q_word.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int r;
    void'($urandom(32'd7));
    rst_n = 1'b0;
    burst_long = 4'b0000;
    bus_valid = 1'b0; bus_last = 1'b0; bus_data = '0; bus_addr = '0; bus_win = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(bus_ready == 1'b1, "R11 ready after reset", 64'(bus_ready), 64'(1));
    chk(req_valid == 1'b0, "R11 no request after reset", 64'(req_valid), 64'(0));
    chk(beat_valid == 1'b0, "R11 no beat after reset", 64'(beat_valid), 64'(0));

    // R5: no memory traffic while the first bank fills
    mem_mode = 2;
    burst_long = 4'b1111;
    bus_addr = 32'h0000_1000;
    bus_win  = 2'd2;
    for (int i = 0; i < 5; i++) send_word(1'b0);
    r = req_seen;
    repeat (12) @(negedge clk);
    chk(req_seen == r, "R5 no request while filling", 64'(req_seen), 64'(r));
    for (int i = 0; i < 11; i++) send_word(i == 10);
    drain_wait();
    chk(req_seen == r + 1, "R3 one request for 16 words", 64'(req_seen), 64'(r + 1));

    // R4: 10 words at depth 8 -> 8 then 2
    burst_long = 4'b0000;
    r = req_seen;
    send_burst(10, 32'h0000_2000, 2'd1);
    drain_wait();
    chk(req_seen == r + 2, "R4 two requests for 10 words", 64'(req_seen), 64'(r + 2));

    // R8: both banks occupied -> bus stalls
    mem_mode = 1;
    bus_addr = 32'h0000_3000;
    bus_win  = 2'd0;
    for (int i = 0; i < 16; i++) send_word(1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bus_valid = 1'b1;
      bus_last  = 1'b0;
      chk(bus_ready == 1'b0, "R8 stall with both banks full", 64'(bus_ready), 64'(0));
    end
    #1 bus_valid = 1'b0;
    mem_mode = 2;
    for (int i = 0; i < 4; i++) send_word(i == 3);
    drain_wait();

    // R9: next burst held off until drained
    mem_mode = 1;
    send_burst(3, 32'h0000_4000, 2'd3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bus_valid = 1'b1;
      chk(bus_ready == 1'b0, "R9 new burst blocked", 64'(bus_ready), 64'(0));
    end
    #1 bus_valid = 1'b0;
    mem_mode = 2;
    drain_wait();
    chk(bus_ready == 1'b1, "R9 ready after drain", 64'(bus_ready), 64'(1));

    // random bursts, setting toggles every cycle (R1 latch), random backpressure
    rand_cfg = 1'b1;
    mem_mode = 0;
    for (int k = 0; k < 40; k++)
      send_burst(1 + int'($urandom % 40), $urandom & 32'h000F_FFFC, 2'($urandom));
    mem_mode = 2;
    drain_wait();
    chk(q_addr.size() == 0 && q_word.size() == 0, "R3 all bursts delivered",
        64'(q_word.size()), 64'(0));
    chk(bus_ready == 1'b1, "R9 idle at end", 64'(bus_ready), 64'(1));

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule